// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block produces the single internal reset of a small processor subsystem. Three causes can request that reset: a power-on event, a sustained low level on the external active-low reset pin, and a watchdog timeout while the watchdog is enabled. Once every request has gone away, the internal reset is held for a fixed number of cycles of the slow watchdog oscillator, which also clocks the whole block. A start-up fuse selects one of two hold lengths. When the hold ends, the block issues a one-cycle strobe that tells the core to load its program counter with address zero.

The supply comparator gives two digital flags. The low-supply flag (supply below the falling threshold) clears all state asynchronously and arms the power-on source. The supply-good flag (supply above the rising threshold) passes through a synchronizer. An armed power-on source holds reset until supply-good is seen, and it then disarms. Toggling supply-good again does nothing until the low-supply flag has been seen once more. The pin passes through the same kind of synchronizer and then through a filter that requires a minimum number of consecutive low samples. Three sticky cause flags record why the last reset happened. Software clears each one with its own strobe.

Top module: `sysrst_sequencer`

## Requirements
- R1: While `sup_low` is 1, `rst_o` is 1 immediately (without waiting for a clock), `vec_ld` is 0 and `cause` is 3'b001.
- R2: After `sup_low` falls, reset stays asserted until `sup_ok` has been seen high through SYNC_STAGES synchronizer flops. The power-on source then fires once and stays disarmed, whatever `sup_ok` does, until `sup_low` is seen again.
- R3: The pin requests reset only after its synchronized value has been low for PIN_FILT consecutive clock edges. A shorter low pulse changes neither `rst_o` nor `cause`.
- R4: A `wd_exp` pulse requests reset only when `wd_en` is 1 in the same cycle. With `wd_en` 0 the pulse changes neither `rst_o` nor `cause`.
- R5: When all requests have dropped, `rst_o` stays 1 for D more clock cycles. D is DLY_SHORT when `fuse_prog` is 1 (fuse programmed) and DLY_LONG when it is 0.
- R6: Any request that arrives while the hold count is running restarts the count from zero.
- R7: `vec_ld` is 1 for exactly one cycle, the first cycle in which `rst_o` is 0 after being 1, and is 0 at all other times.
- R8: `cause` bit 0 records power-on, bit 1 the pin, bit 2 the watchdog. A bit is set while its source requests reset. A bit is cleared only by a 1 on the matching bit of `flag_clr`, and setting wins over clearing.
- R9: When the power-on source fires, `cause` bits 1 and 2 are cleared unless their own source requests reset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wdo_clk | input | 1 | Watchdog oscillator clock; all state runs on it |
| sup_low | input | 1 | Supply below the falling threshold; asynchronous clear, arms power-on |
| sup_ok | input | 1 | Supply above the rising threshold (asynchronous, synchronized inside) |
| pin_n | input | 1 | Raw external reset pin, active low (asynchronous) |
| wd_exp | input | 1 | One-cycle watchdog timeout pulse, on `wdo_clk` |
| wd_en | input | 1 | Watchdog enable |
| fuse_prog | input | 1 | Start-up fuse: 1 = programmed (short hold), 0 = long hold |
| flag_clr | input | 3 | Per-bit write-zero strobe for `cause` |
| rst_o | output | 1 | Internal reset, active high |
| vec_ld | output | 1 | One-cycle strobe: load program counter with address 0 |
| cause | output | 3 | Sticky reset cause flags (power-on, pin, watchdog) |

## Verification
The bench builds the block with SYNC_STAGES=2, PIN_FILT=4, DLY_SHORT=6 and DLY_LONG=20. With these values a three-cycle pin glitch can be set against a four-cycle threshold, and both hold lengths fit in a short run. A watchdog retrigger ten cycles into a twenty-cycle hold shows clearly that the count restarts. Exact hold widths are measured from the stimulus edge for each source, so the synchronizer and filter latency enter every expected number.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
   localparam int unsigned NUM_SRC = 3;
   typedef enum logic [1:0] {
      SRC_POR = 2'd0,
      SRC_PIN = 2'd1,
      SRC_WDT = 2'd2
   } rst_src_e;
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("sysrst_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= {STAGES{RST_VAL}};
      else      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
   parameter int unsigned FILT = 4
) (
   input  logic clk,
   input  logic arst,
   input  logic pin_s_n,
   output logic req
);
   generate
      if (FILT == 0) begin : g_pass
         assign req = ~pin_s_n;
      end else begin : g_cnt
         localparam int unsigned W = $clog2(FILT + 1);
         localparam logic [W-1:0] LIMIT = W'(FILT);
         logic [W-1:0] low_cnt;

         always_ff @(posedge clk or posedge arst) begin
            if (arst)                 low_cnt <= '0;
            else if (pin_s_n)         low_cnt <= '0;
            else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
         end

         assign req = (low_cnt == LIMIT);

         // R3
         pin_glitch_chk: assert property (@(posedge clk) disable iff (arst)
            req |-> $past(!pin_s_n));
      end
   endgenerate
endmodule

// File: rtl/sysrst_delay.sv
module sysrst_delay #(
   parameter int unsigned DLY_SHORT = 16,
   parameter int unsigned DLY_LONG  = 512
) (
   input  logic clk,
   input  logic arst,
   input  logic req,
   input  logic fuse_prog,
   output logic rst_o,
   output logic vec_ld
);
   localparam int unsigned CW = $clog2(DLY_LONG + 1);
   localparam logic [CW-1:0] LAST_S = CW'(DLY_SHORT - 1);
   localparam logic [CW-1:0] LAST_L = CW'(DLY_LONG - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = fuse_prog ? LAST_S : LAST_L;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         cnt    <= '0;
         rst_o  <= 1'b1;
         vec_ld <= 1'b0;
      end else begin
         vec_ld <= 1'b0;
         if (req) begin
            rst_o <= 1'b1;
            cnt   <= '0;
         end else if (rst_o) begin
            if (cnt >= last) begin
               rst_o  <= 1'b0;
               cnt    <= '0;
               vec_ld <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (arst)
      req |=> rst_o);
   // R7
   vec_after_rel_chk: assert property (@(posedge clk) disable iff (arst)
      vec_ld |-> (!rst_o && $past(rst_o)));
   // R7
   rel_strobe_chk: assert property (@(posedge clk) disable iff (arst)
      $fell(rst_o) |-> vec_ld);
   // R5
   stay_free_chk: assert property (@(posedge clk) disable iff (arst)
      (!rst_o && !req) |=> !rst_o);
endmodule

// File: rtl/sysrst_flags.sv
module sysrst_flags
   import sysrst_pkg::*;
(
   input  logic               clk,
   input  logic               arst,
   input  logic               por_fire,
   input  logic               pin_req,
   input  logic               wd_req,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] flags
);
   localparam int P_POR = int'(SRC_POR);
   localparam int P_PIN = int'(SRC_PIN);
   localparam int P_WDT = int'(SRC_WDT);

   logic [NUM_SRC-1:0] set_v;
   assign set_v[P_POR] = por_fire;
   assign set_v[P_PIN] = pin_req;
   assign set_v[P_WDT] = wd_req;

   generate
      for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_bit
         if (i == P_POR) begin : g_por
            always_ff @(posedge clk or posedge arst) begin
               if (arst)          flags[i] <= 1'b1;
               else if (set_v[i]) flags[i] <= 1'b1;
               else if (clr[i])   flags[i] <= 1'b0;
            end
         end else begin : g_other
            always_ff @(posedge clk or posedge arst) begin
               if (arst)                     flags[i] <= 1'b0;
               else if (set_v[i])            flags[i] <= 1'b1;
               else if (clr[i] || por_fire)  flags[i] <= 1'b0;
            end
         end
      end
   endgenerate

   // R8
   pin_flag_src_chk: assert property (@(posedge clk) disable iff (arst)
      $rose(flags[P_PIN]) |-> $past(pin_req));
   // R8
   wdt_flag_src_chk: assert property (@(posedge clk) disable iff (arst)
      $rose(flags[P_WDT]) |-> $past(wd_req));
   // R9
   por_clears_chk: assert property (@(posedge clk) disable iff (arst)
      (por_fire && !pin_req && !wd_req) |=> (flags[P_PIN] == 1'b0 && flags[P_WDT] == 1'b0));
endmodule

// File: rtl/sysrst_sequencer.sv
module sysrst_sequencer
   import sysrst_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PIN_FILT    = 4,
   parameter int unsigned DLY_SHORT   = 16,
   parameter int unsigned DLY_LONG    = 512
) (
   input  logic               wdo_clk,
   input  logic               sup_low,
   input  logic               sup_ok,
   input  logic               pin_n,
   input  logic               wd_exp,
   input  logic               wd_en,
   input  logic               fuse_prog,
   input  logic [NUM_SRC-1:0] flag_clr,
   output logic               rst_o,
   output logic               vec_ld,
   output logic [NUM_SRC-1:0] cause
);
   generate
      if (DLY_SHORT < 1) begin : g_bad_short
         $error("sysrst_sequencer: DLY_SHORT must be at least 1");
      end
      if (DLY_LONG < DLY_SHORT) begin : g_bad_long
         $error("sysrst_sequencer: DLY_LONG must not be below DLY_SHORT");
      end
   endgenerate

   logic pin_s_n;
   logic ok_s;
   logic pin_req;
   logic wd_req;
   logic armed;
   logic por_fire;
   logic any_req;

   sysrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk(wdo_clk), .arst(sup_low), .d(pin_n), .q(pin_s_n));

   sysrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ok_sync (
      .clk(wdo_clk), .arst(sup_low), .d(sup_ok), .q(ok_s));

   sysrst_pin_filter #(.FILT(PIN_FILT)) u_filt (
      .clk(wdo_clk), .arst(sup_low), .pin_s_n(pin_s_n), .req(pin_req));

   always_ff @(posedge wdo_clk or posedge sup_low) begin
      if (sup_low) begin
         armed  <= 1'b1;
         wd_req <= 1'b0;
      end else begin
         if (ok_s) armed <= 1'b0;
         wd_req <= wd_exp & wd_en;
      end
   end

   assign por_fire = armed & ok_s;
   assign any_req  = armed | pin_req | wd_req;

   sysrst_delay #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_dly (
      .clk(wdo_clk), .arst(sup_low), .req(any_req), .fuse_prog(fuse_prog),
      .rst_o(rst_o), .vec_ld(vec_ld));

   sysrst_flags u_flags (
      .clk(wdo_clk), .arst(sup_low), .por_fire(por_fire), .pin_req(pin_req),
      .wd_req(wd_req), .clr(flag_clr), .flags(cause));

   // R2
   no_rearm_chk: assert property (@(posedge wdo_clk) disable iff (sup_low)
      !armed |=> !armed);
   // R4
   wd_gate_chk: assert property (@(posedge wdo_clk) disable iff (sup_low)
      (wd_exp && !wd_en) |=> !wd_req);
endmodule

// File: tb/sysrst_sequencer_tb.sv
module sysrst_sequencer_tb;
   localparam int SYNC = 2;
   localparam int FILT = 4;
   localparam int DS   = 6;
   localparam int DL   = 20;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       sup_low = 1'b1, sup_ok = 1'b0, pin_n = 1'b1;
   logic       wd_exp = 1'b0, wd_en = 1'b0, fuse_prog = 1'b1;
   logic [2:0] flag_clr = 3'b000;
   logic       rst_o, vec_ld;
   logic [2:0] cause;

   int checks = 0;
   int errors = 0;

   sysrst_sequencer #(.SYNC_STAGES(SYNC), .PIN_FILT(FILT), .DLY_SHORT(DS), .DLY_LONG(DL)) u_dut (
      .wdo_clk(clk), .sup_low(sup_low), .sup_ok(sup_ok), .pin_n(pin_n),
      .wd_exp(wd_exp), .wd_en(wd_en), .fuse_prog(fuse_prog), .flag_clr(flag_clr),
      .rst_o(rst_o), .vec_ld(vec_ld), .cause(cause));

   // behavioural reference: queues delay the asynchronous inputs
   bit         pq[$];
   bit         oq[$];
   int         m_low = 0;
   int         m_cnt = 0;
   bit         m_armed = 1, m_wd = 0, m_rst = 1, m_vec = 0;
   logic [2:0] m_flag = 3'b001;

   always @(posedge clk) begin
      if (sup_low) begin
         pq.delete();
         oq.delete();
         for (int i = 0; i < SYNC; i++) begin
            pq.push_back(1'b1);
            oq.push_back(1'b0);
         end
         m_low = 0; m_cnt = 0; m_armed = 1; m_wd = 0;
         m_rst = 1; m_vec = 0; m_flag = 3'b001;
      end else begin : step
         bit ps, os, preq, fire, anyr;
         int last;
         ps   = pq[0];
         os   = oq[0];
         preq = (m_low >= FILT);
         fire = m_armed && os;
         anyr = m_armed || preq || m_wd;
         last = fuse_prog ? DS - 1 : DL - 1;
         m_vec = 0;
         if (anyr) begin
            m_rst = 1; m_cnt = 0;
         end else if (m_rst) begin
            if (m_cnt >= last) begin m_rst = 0; m_cnt = 0; m_vec = 1; end
            else m_cnt++;
         end
         if (fire) m_flag[0] = 1'b1;
         else if (flag_clr[0]) m_flag[0] = 1'b0;
         if (preq) m_flag[1] = 1'b1;
         else if (fire || flag_clr[1]) m_flag[1] = 1'b0;
         if (m_wd) m_flag[2] = 1'b1;
         else if (fire || flag_clr[2]) m_flag[2] = 1'b0;
         m_low = ps ? 0 : ((m_low < FILT) ? m_low + 1 : m_low);
         if (os) m_armed = 0;
         m_wd = wd_exp && wd_en;
         void'(pq.pop_front());
         pq.push_back(pin_n);
         void'(oq.pop_front());
         oq.push_back(sup_ok);
      end
   end

   always @(negedge clk) begin
      checks++;
      if ({rst_o, vec_ld, cause} !== {m_rst, m_vec, m_flag}) begin
         errors++;
         $display("FAIL model R5 R7 R8 t=%0t actual rst=%b vec=%b cause=%b expected rst=%b vec=%b cause=%b",
                  $time, rst_o, vec_ld, cause, m_rst, m_vec, m_flag);
      end
   end

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(output int n);
      n = 0;
      forever begin
         @(negedge clk);
         if (rst_o) n++;
         else break;
      end
   endtask

   task automatic pulse_wd();
      @(negedge clk); #2 wd_exp = 1'b1;
      @(negedge clk); #2 wd_exp = 1'b0;
   endtask

   task automatic run_all();
      int n;
      cyc(3);
      chk("R1 rst under low supply", int'(rst_o), 1);
      chk("R1 no vector strobe", int'(vec_ld), 0);
      chk("R1 cause after power loss", int'(cause), 1);

      @(negedge clk); #2 sup_low = 1'b0;
      cyc(10);
      chk("R2 held until supply good", int'(rst_o), 1);

      @(negedge clk); #2 sup_ok = 1'b1;
      measure(n);
      chk("R2 R5 power-on hold width", n, SYNC + DS);
      chk("R7 strobe on release", int'(vec_ld), 1);
      cyc(1);
      chk("R7 strobe one cycle", int'(vec_ld), 0);
      chk("R8 power-on cause", int'(cause), 1);

      // R2: supply-good toggling without low supply does nothing
      @(negedge clk); #2 sup_ok = 1'b0;
      cyc(5); #2 sup_ok = 1'b1;
      cyc(10);
      chk("R2 no re-fire", int'(rst_o), 0);

      // R3 glitch
      @(negedge clk); #2 pin_n = 1'b0;
      repeat (FILT - 1) @(negedge clk);
      #2 pin_n = 1'b1;
      cyc(8);
      chk("R3 short pulse ignored rst", int'(rst_o), 0);
      chk("R3 short pulse ignored flag", int'(cause[1]), 0);

      // R3 sustained low
      @(negedge clk); #2 pin_n = 1'b0;
      cyc(10);
      chk("R3 long low asserts", int'(rst_o), 1);
      chk("R8 pin cause", int'(cause[1]), 1);
      #2 flag_clr = 3'b010;
      @(negedge clk); #2 flag_clr = 3'b000;
      chk("R8 set wins over clear", int'(cause[1]), 1);
      pin_n = 1'b1;
      measure(n);
      chk("R5 pin release hold width", n, SYNC + DS);

      cyc(2);
      #2 flag_clr = 3'b010;
      @(negedge clk); #2 flag_clr = 3'b000;
      chk("R8 clear strobe", int'(cause), 1);

      // R4 disabled watchdog
      wd_en = 1'b0;
      pulse_wd();
      cyc(5);
      chk("R4 disabled expiry rst", int'(rst_o), 0);
      chk("R4 disabled expiry flag", int'(cause[2]), 0);

      // R4 enabled, long fuse
      fuse_prog = 1'b0;
      wd_en = 1'b1;
      pulse_wd();
      measure(n);
      chk("R4 R5 unprogrammed hold width", n, DL);
      chk("R7 strobe after watchdog", int'(vec_ld), 1);
      chk("R8 watchdog cause", int'(cause), 5);

      // R6 restart
      cyc(2);
      pulse_wd();
      cyc(8);
      pulse_wd();
      measure(n);
      chk("R6 restart on new request", n, DL);

      // short fuse through watchdog
      fuse_prog = 1'b1;
      cyc(2);
      pulse_wd();
      measure(n);
      chk("R5 programmed hold width", n, DS);

      cyc(2);
      #2 flag_clr = 3'b111;
      @(negedge clk); #2 flag_clr = 3'b000;
      chk("R8 clear all", int'(cause), 0);

      // R1 asynchronous and R9
      @(negedge clk); #2 sup_low = 1'b1; sup_ok = 1'b0;
      #1;
      chk("R1 asynchronous assertion", int'(rst_o), 1);
      cyc(2);
      chk("R1 cause reset value", int'(cause), 1);
      #2 sup_low = 1'b0;
      cyc(3);
      pulse_wd();
      cyc(2);
      chk("R8 watchdog flag while armed", int'(cause), 5);
      #2 sup_ok = 1'b1;
      cyc(6);
      chk("R9 power-on clears others", int'(cause), 1);
      measure(n);
      cyc(2);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired: actual hung expected stimulus complete");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule